// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block steps a chip into and out of three low-power levels: stop, standby and shutdown. The CPU raises a one-cycle request together with a level code. The controller then waits until neither a flash program operation nor a peripheral-bus access is still running, and only then enters the requested level. While it waits, a wakeup event calls the entry off and returns it to run with no clock change.

On wakeup the controller sets the system clock source and the multi-speed oscillator (MSO) settings for the level being left, and then holds clock-ready low for a settling window. When stop is left with the MSO selected, and the MSO was locked to the low-speed external reference at entry, the window is the longer lock wait. Oscillator settling is modelled only as cycle counts.

Top module: `lpm_seq`

## Requirements
- R1: After reset the state is RUN (code 0), clkReady is 1, clkSrcHsi is 0, presClr is 0, msoRange is RANGE_4MHZ (default 6) and msoTrim is TRIM_DEFAULT (default 16).
- R2: In RUN, lpReq with lpKind 0 (stop), 1 (standby) or 2 (shutdown) moves the state to WAIT_IDLE (code 1) at the next edge. lpKind 3 is ignored and the state stays RUN.
- R3: WAIT_IDLE moves to STOP (2), STANDBY (3) or SHUTDOWN (4) only at an edge where flashBusy and apbBusy are both low. While either is high it stays in WAIT_IDLE.
- R4: A wakeEvt seen in WAIT_IDLE returns the state to RUN at the next edge and leaves clkSrcHsi, msoRange and msoTrim unchanged. This holds even when both busy flags are low in that cycle.
- R5: A low-power state holds until wakeEvt. clkReady is 1 in RUN and WAIT_IDLE and 0 in every other state.
- R6: On leaving stop, clkSrcHsi takes the value of wakeSelHsi at the wake edge. msoRange and msoTrim return to the values of savedRange and savedTrim sampled at the entry edge, so later changes to those inputs have no effect.
- R7: presClr is 1 for exactly the first WAKE_SETTLE cycle when stop is left with clkSrcHsi selected. It is never 1 otherwise.
- R8: On leaving standby, clkSrcHsi is 0, msoRange is RANGE_4MHZ, and msoTrim is the trim sampled at entry.
- R9: On leaving shutdown, clkSrcHsi is 0, msoRange is RANGE_4MHZ and msoTrim is TRIM_DEFAULT.
- R10: WAKE_SETTLE (code 5) lasts LOCK_CYCLES cycles (default 16) when stop is left with wakeSelHsi 0 and pllMode was 1 at entry, and OSC_CYCLES cycles (default 4) otherwise. The state then becomes RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lpReq | input | 1 | Low-power entry request |
| lpKind | input | 2 | Requested level: 0 stop, 1 standby, 2 shutdown, 3 reserved |
| wakeEvt | input | 1 | Wakeup event |
| flashBusy | input | 1 | Flash program operation in progress |
| apbBusy | input | 1 | Peripheral bus access in progress |
| wakeSelHsi | input | 1 | Stop-exit clock select: 1 = 16 MHz oscillator, 0 = MSO |
| savedRange | input | RANGE_W | MSO range in use before entry |
| savedTrim | input | TRIM_W | MSO user trim in use before entry |
| pllMode | input | 1 | MSO locked to low-speed external reference |
| lpState | output | 3 | Controller state code |
| clkSrcHsi | output | 1 | System clock source: 1 = 16 MHz oscillator |
| msoRange | output | RANGE_W | MSO range setting |
| msoTrim | output | TRIM_W | MSO trim setting |
| presClr | output | 1 | Strobe clearing the secondary core prescaler |
| clkReady | output | 1 | System clock usable |

## Verification
A request moves lpState one edge after lpReq is sampled. Entry to a low-power state lands one edge after the first cycle with both busy flags low, and a cancel reaches RUN one edge after wakeEvt. The clock source, range, trim and presClr values are registered, so they are due in the first WAKE_SETTLE cycle, one edge after wakeEvt. RUN returns exactly OSC_CYCLES or LOCK_CYCLES edges after that. The bench drives and samples 2 ns after each rising edge and compares every cycle of each window with a value computed from the level, the select bit and the inputs sampled at entry.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN         = 3'd0,
    ST_WAIT_IDLE   = 3'd1,
    ST_STOP        = 3'd2,
    ST_STANDBY     = 3'd3,
    ST_SHUTDOWN    = 3'd4,
    ST_WAKE_SETTLE = 3'd5
  } lpState_e;

  typedef enum logic [1:0] {
    KIND_STOP     = 2'd0,
    KIND_STANDBY  = 2'd1,
    KIND_SHUTDOWN = 2'd2,
    KIND_RSVD     = 2'd3
  } lpKind_e;

  // strobes from control to the clock-setting datapath
  typedef struct packed {
    logic    captureEn;  // sample saved settings at entry
    logic    applyEn;    // load wake settings
    lpKind_e fromKind;   // level being left
    logic    useHsi;     // stop exit onto the 16 MHz oscillator
  } dpCtl_t;

endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int OSC_CYCLES  = 4,
  parameter int LOCK_CYCLES = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     lpReq,
  input  logic [1:0] lpKind,
  input  logic     wakeEvt,
  input  logic     flashBusy,
  input  logic     apbBusy,
  input  logic     wakeSelHsi,
  input  logic     lockSaved,
  output lpState_e state,
  output dpCtl_t   ctl,
  output logic     clkReady
);

  localparam int MAX_CYC = (LOCK_CYCLES > OSC_CYCLES) ? LOCK_CYCLES : OSC_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] OSC_LD  = CNT_W'(OSC_CYCLES - 1);
  localparam logic [CNT_W-1:0] LOCK_LD = CNT_W'(LOCK_CYCLES - 1);

  lpState_e stateD;
  lpKind_e  kindQ, kindD;
  logic [CNT_W-1:0] cnt, cntD;
  logic inLowPower;

  assign inLowPower = (state == ST_STOP) || (state == ST_STANDBY) || (state == ST_SHUTDOWN);

  function automatic lpState_e targetOf(lpKind_e k);
    case (k)
      KIND_STANDBY:  return ST_STANDBY;
      KIND_SHUTDOWN: return ST_SHUTDOWN;
      default:       return ST_STOP;
    endcase
  endfunction

  always_comb begin
    stateD       = state;
    kindD        = kindQ;
    cntD         = cnt;
    ctl          = '0;
    ctl.fromKind = kindQ;
    case (state)
      ST_RUN: begin
        if (lpReq && (lpKind != KIND_RSVD)) begin
          stateD = ST_WAIT_IDLE;
          kindD  = lpKind_e'(lpKind);
        end
      end
      ST_WAIT_IDLE: begin
        if (wakeEvt) begin
          stateD = ST_RUN;
        end else if (!flashBusy && !apbBusy) begin
          ctl.captureEn = 1'b1;
          stateD        = targetOf(kindQ);
        end
      end
      ST_STOP, ST_STANDBY, ST_SHUTDOWN: begin
        if (wakeEvt) begin
          ctl.applyEn = 1'b1;
          ctl.useHsi  = (kindQ == KIND_STOP) && wakeSelHsi;
          stateD      = ST_WAKE_SETTLE;
          cntD        = ((kindQ == KIND_STOP) && !wakeSelHsi && lockSaved) ? LOCK_LD : OSC_LD;
        end
      end
      ST_WAKE_SETTLE: begin
        if (cnt == '0) stateD = ST_RUN;
        else           cntD   = cnt - 1'b1;
      end
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_RUN;
      kindQ <= KIND_STOP;
      cnt   <= '0;
    end else begin
      state <= stateD;
      kindQ <= kindD;
      cnt   <= cntD;
    end
  end

  assign clkReady = (state == ST_RUN) || (state == ST_WAIT_IDLE);

  // R3
  enter_only_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inLowPower && $past(state) == ST_WAIT_IDLE) |-> $past(!flashBusy && !apbBusy));

  // R4
  cancel_to_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_IDLE && wakeEvt) |=> (state == ST_RUN));

  // R5
  lp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inLowPower && !wakeEvt) |=> $stable(state));

  // R10
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAKE_SETTLE && cnt != '0) |=> (state == ST_WAKE_SETTLE));

  // R2
  rsvd_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && lpReq && lpKind == 2'd3) |=> (state == ST_RUN));

endmodule

// File: rtl/lpm_clkpath.sv
module lpm_clkpath
  import lpm_pkg::*;
#(
  parameter int RANGE_W      = 4,
  parameter int TRIM_W       = 8,
  parameter int RANGE_4MHZ   = 6,
  parameter int TRIM_DEFAULT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [RANGE_W-1:0] savedRange,
  input  logic [TRIM_W-1:0]  savedTrim,
  input  logic               pllMode,
  output logic               clkSrcHsi,
  output logic [RANGE_W-1:0] msoRange,
  output logic [TRIM_W-1:0]  msoTrim,
  output logic               presClr,
  output logic               lockSaved
);

  localparam logic [RANGE_W-1:0] RANGE_RST = RANGE_W'(RANGE_4MHZ);
  localparam logic [TRIM_W-1:0]  TRIM_RST  = TRIM_W'(TRIM_DEFAULT);

  logic [RANGE_W-1:0] capRange;
  logic [TRIM_W-1:0]  capTrim;

  // settings held across the low-power interval
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capRange  <= RANGE_RST;
      capTrim   <= TRIM_RST;
      lockSaved <= 1'b0;
    end else if (ctl.captureEn) begin
      capRange  <= savedRange;
      capTrim   <= savedTrim;
      lockSaved <= pllMode;
    end
  end

  // wake-time clock selection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSrcHsi <= 1'b0;
      msoRange  <= RANGE_RST;
      msoTrim   <= TRIM_RST;
      presClr   <= 1'b0;
    end else begin
      presClr <= ctl.applyEn && ctl.useHsi;
      if (ctl.applyEn) begin
        case (ctl.fromKind)
          KIND_STOP: begin
            clkSrcHsi <= ctl.useHsi;
            msoRange  <= capRange;
            msoTrim   <= capTrim;
          end
          KIND_STANDBY: begin
            clkSrcHsi <= 1'b0;
            msoRange  <= RANGE_RST;
            msoTrim   <= capTrim;
          end
          default: begin
            clkSrcHsi <= 1'b0;
            msoRange  <= RANGE_RST;
            msoTrim   <= TRIM_RST;
          end
        endcase
      end
    end
  end

  // R9
  shutdown_default_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.applyEn && ctl.fromKind == KIND_SHUTDOWN) |=>
      (msoTrim == TRIM_RST && msoRange == RANGE_RST && !clkSrcHsi));

  // R7
  presclr_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    presClr |-> clkSrcHsi);

  // R7
  presclr_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    presClr |=> !presClr);

  // R6
  hold_no_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.applyEn |=> ($stable(clkSrcHsi) && $stable(msoRange) && $stable(msoTrim)));

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int RANGE_W      = 4,
  parameter int TRIM_W       = 8,
  parameter int RANGE_4MHZ   = 6,
  parameter int TRIM_DEFAULT = 16,
  parameter int OSC_CYCLES   = 4,
  parameter int LOCK_CYCLES  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lpReq,
  input  logic [1:0]         lpKind,
  input  logic               wakeEvt,
  input  logic               flashBusy,
  input  logic               apbBusy,
  input  logic               wakeSelHsi,
  input  logic [RANGE_W-1:0] savedRange,
  input  logic [TRIM_W-1:0]  savedTrim,
  input  logic               pllMode,
  output logic [2:0]         lpState,
  output logic               clkSrcHsi,
  output logic [RANGE_W-1:0] msoRange,
  output logic [TRIM_W-1:0]  msoTrim,
  output logic               presClr,
  output logic               clkReady
);

  lpState_e state;
  dpCtl_t   ctl;
  logic     lockSaved;

  lpm_ctrl #(
    .OSC_CYCLES (OSC_CYCLES),
    .LOCK_CYCLES(LOCK_CYCLES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .lpReq     (lpReq),
    .lpKind    (lpKind),
    .wakeEvt   (wakeEvt),
    .flashBusy (flashBusy),
    .apbBusy   (apbBusy),
    .wakeSelHsi(wakeSelHsi),
    .lockSaved (lockSaved),
    .state     (state),
    .ctl       (ctl),
    .clkReady  (clkReady)
  );

  lpm_clkpath #(
    .RANGE_W     (RANGE_W),
    .TRIM_W      (TRIM_W),
    .RANGE_4MHZ  (RANGE_4MHZ),
    .TRIM_DEFAULT(TRIM_DEFAULT)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .savedRange(savedRange),
    .savedTrim (savedTrim),
    .pllMode   (pllMode),
    .clkSrcHsi (clkSrcHsi),
    .msoRange  (msoRange),
    .msoTrim   (msoTrim),
    .presClr   (presClr),
    .lockSaved (lockSaved)
  );

  assign lpState = state;

endmodule

// File: tb/tb_lpm_seq.sv
`timescale 1ns/1ps
module tb_lpm_seq;

  localparam int RANGE_W = 4, TRIM_W = 8, R4M = 6, TDEF = 16, OSC = 4, LOCK = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic lpReq = 0, wakeEvt = 0, flashBusy = 0, apbBusy = 0, wakeSelHsi = 0, pllMode = 0;
  logic [1:0] lpKind = 0;
  logic [RANGE_W-1:0] savedRange = 0;
  logic [TRIM_W-1:0]  savedTrim = 0;
  logic [2:0] lpState;
  logic clkSrcHsi, presClr, clkReady;
  logic [RANGE_W-1:0] msoRange;
  logic [TRIM_W-1:0]  msoTrim;

  int nChecks = 0, nFail = 0;
  bit done = 0;
  int expSrc = 0, expRange = R4M, expTrim = TDEF;

  always #5 clk = ~clk;

  lpm_seq dut (
    .clk(clk), .rstN(rstN), .lpReq(lpReq), .lpKind(lpKind), .wakeEvt(wakeEvt),
    .flashBusy(flashBusy), .apbBusy(apbBusy), .wakeSelHsi(wakeSelHsi),
    .savedRange(savedRange), .savedTrim(savedTrim), .pllMode(pllMode),
    .lpState(lpState), .clkSrcHsi(clkSrcHsi), .msoRange(msoRange), .msoTrim(msoTrim),
    .presClr(presClr), .clkReady(clkReady)
  );

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic int targetState(int k);
    return k + 2;
  endfunction

  function automatic int expRangeF(int k, int capR);
    return (k == 0) ? capR : R4M;
  endfunction

  function automatic int expTrimF(int k, int capT);
    return (k == 2) ? TDEF : capT;
  endfunction

  function automatic int settleLen(int k, bit hsi, bit pll);
    return (k == 0 && !hsi && pll) ? LOCK : OSC;
  endfunction

  task automatic chkClocks(string req);
    chk(req, "clkSrcHsi", clkSrcHsi, expSrc);
    chk(req, "msoRange", msoRange, expRange);
    chk(req, "msoTrim", msoTrim, expTrim);
  endtask

  // one entry attempt: cancelAt < 0 means no cancel
  task automatic runEntry(int kind, int busyCycles, int capR, int capT, bit pll,
                          int cancelAt, bit hsi, int hold);
    int dur;
    lpReq = 1; lpKind = kind[1:0];
    savedRange = capR[RANGE_W-1:0]; savedTrim = capT[TRIM_W-1:0]; pllMode = pll;
    step();
    lpReq = 0;
    if (kind == 3) begin
      chk("R2", "reserved request state", lpState, 0);
      chkClocks("R2");
      return;
    end
    chk("R2", "request state", lpState, 1);
    chk("R5", "clkReady in WAIT_IDLE", clkReady, 1);
    for (int i = 0; i <= busyCycles; i++) begin
      if (i < busyCycles) begin
        flashBusy = $urandom_range(0, 1);
        apbBusy   = flashBusy ? $urandom_range(0, 1) : 1'b1;
      end else begin
        flashBusy = 0; apbBusy = 0;
      end
      wakeEvt = (i == cancelAt);
      step();
      if (i == cancelAt) begin
        wakeEvt = 0; flashBusy = 0; apbBusy = 0;
        chk("R4", "cancel state", lpState, 0);
        chkClocks("R4");
        chk("R4", "clkReady after cancel", clkReady, 1);
        return;
      end
      if (i < busyCycles) chk("R3", "held while busy", lpState, 1);
    end
    chk("R3", "entry state", lpState, targetState(kind));
    chk("R5", "clkReady low-power", clkReady, 0);
    // settings changed after entry must not matter (R6)
    savedRange = $urandom_range(0, 15); savedTrim = $urandom_range(0, 255); pllMode = !pll;
    for (int h = 0; h < hold; h++) begin
      step();
      chk("R5", "low-power hold", lpState, targetState(kind));
    end
    wakeEvt = 1; wakeSelHsi = hsi;
    step();
    wakeEvt = 0; wakeSelHsi = $urandom_range(0, 1);
    expSrc   = (kind == 0) ? int'(hsi) : 0;
    expRange = expRangeF(kind, capR);
    expTrim  = expTrimF(kind, capT);
    chk("R10", "settle state", lpState, 5);
    chk("R5", "clkReady settling", clkReady, 0);
    chkClocks(kind == 0 ? "R6" : (kind == 1 ? "R8" : "R9"));
    chk("R7", "presClr first cycle", presClr, (kind == 0 && hsi) ? 1 : 0);
    dur = settleLen(kind, hsi, pll);
    for (int c = 1; c < dur; c++) begin
      step();
      chk("R10", "still settling", lpState, 5);
      chk("R7", "presClr later", presClr, 0);
    end
    step();
    chk("R10", "back to RUN", lpState, 0);
    chk("R10", "clkReady restored", clkReady, 1);
    chkClocks("R6");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    step();
    // R1 reset values
    chk("R1", "state", lpState, 0);
    chk("R1", "clkReady", clkReady, 1);
    chk("R1", "presClr", presClr, 0);
    chkClocks("R1");
    // directed corners
    runEntry(0, 3, 9, 77, 0, -1, 1, 2);   // stop, HSI exit, prescaler clear
    runEntry(0, 0, 3, 200, 1, -1, 0, 1);  // stop, MSO locked -> long wait
    runEntry(0, 2, 11, 5, 1, -1, 1, 0);   // stop, HSI exit with lock flag: short wait
    runEntry(0, 1, 2, 40, 0, -1, 0, 3);   // stop, MSO no lock
    runEntry(1, 4, 13, 99, 1, -1, 1, 2);  // standby
    runEntry(2, 2, 1, 250, 1, -1, 1, 1);  // shutdown
    runEntry(3, 0, 7, 7, 0, -1, 0, 0);    // reserved kind ignored
    runEntry(0, 3, 4, 4, 0, 1, 0, 0);     // cancel while busy
    runEntry(1, 2, 4, 4, 0, 2, 0, 0);     // cancel when idle: wake wins
    runEntry(2, 10, 5, 60, 0, -1, 0, 0);  // long busy
    // random mix
    for (int n = 0; n < 60; n++) begin
      int k, b, ca;
      k  = $urandom_range(0, 3);
      b  = $urandom_range(0, 6);
      ca = ($urandom_range(0, 4) == 0) ? $urandom_range(0, b) : -1;
      runEntry(k, b, $urandom_range(0, 15), $urandom_range(0, 255), 1'($urandom_range(0, 1)),
               ca, 1'($urandom_range(0, 1)), $urandom_range(0, 4));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule